// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Clock Output

This block is a transmit-only serial master. It sends framed characters on a data line and drives a matching clock output, so a plain shift register or a shift-register-like peripheral can capture the data bits. Each character is framed as a low start bit, then the data bits least-significant first, then a high stop bit. The clock pulses only during data bits. It stays at its idle level during the start bit, the stop bit and idle time, so consecutive characters always have a gap in the clock.

Software or a DMA engine loads words through a one-word holding register with a valid/ready handshake. A request output asks for the next word whenever the holding register is empty and DMA transmit is on. The configuration inputs are these:

- clock polarity and clock phase, with the same meaning as SPI modes 0 to 3;
- a switch that gives or withholds a clock pulse on the final data bit;
- the word length, 8 or 9 bits;
- an oversampling select, 16 or 8 input cycles per divider step;
- an integer baud divider.

The configuration is assumed to stay stable while a character is in flight.

Top module: `sync_serial_tx`

## Requirements
- R1: `tx_data` is 1 when idle. A character is one start bit at 0, then the data bits with bit 0 first, then one stop bit at 1.
- R2: With `word9`=0 the bits `wr_data[7:0]` are sent and `wr_data[8]` is ignored. With `word9`=1 nine bits are sent, and `wr_data[8]` is the last one.
- R3: Every bit lasts D×16 input clock cycles, or D×8 cycles when `over8`=1. D is `baud_div`, except that a `baud_div` of 0 acts as 1.
- R4: `tx_clk` equals `cpol` when idle and during start and stop bits.
- R5: Within a clocked data bit, `cpha`=0 puts `tx_clk` at `cpol` for the first half of the bit and at the inverse for the second half. `cpha`=1 gives the reverse order.
- R6: With `last_clk`=0 the final data bit of each character has no clock pulse. With `last_clk`=1 it is clocked like the other data bits.
- R7: The block accepts words and starts characters only while `en_global` and `en_tx` are both 1. A character already started always finishes.
- R8: A word accepted while the shifter is idle starts its start bit on the next clock edge. A word accepted during a character starts right after that character's stop bit, with no idle bit in between.
- R9: `txe` is 0 exactly while the holding register is full. `wr_ready` equals enable AND `txe`.
- R10: `tc` is 1 after reset. It clears when a word is accepted. It sets when a stop bit ends and no word is waiting.
- R11: `dma_req` equals `dma_en` AND enable AND `txe`.
- R12: After reset, `tx_data`=1, `tx_clk`=`cpol`, `txe`=1 and `tc`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_global | input | 1 | Block enable |
| en_tx | input | 1 | Transmitter enable |
| dma_en | input | 1 | Enables the DMA request output |
| cpol | input | 1 | Idle level of `tx_clk` |
| cpha | input | 1 | 0: sample on first edge, 1: sample on second edge |
| last_clk | input | 1 | 1: clock the final data bit |
| word9 | input | 1 | 1: 9 data bits, 0: 8 data bits |
| over8 | input | 1 | 1: 8 cycles per divider step, 0: 16 |
| baud_div | input | DIV_W | Integer baud divider (0 acts as 1) |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send |
| wr_ready | output | 1 | Holding register can take a word |
| dma_req | output | 1 | DMA transfer request |
| tx_data | output | 1 | Serial data out |
| tx_clk | output | 1 | Serial clock out |
| txe | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |

## Verification
A word accepted at an edge clears `txe` and `tc` on that edge. When the shifter is idle, the next edge turns `tx_data` low for the start bit and sets `txe` again. Each later bit boundary falls a whole bit period after the one before it. Clock edges sit at the bit's midpoint and at its end. `wr_ready` and `dma_req` follow the enables combinationally within the same cycle.

The bench's model works out the full per-cycle waveform of a character at the edge where the character starts, and plays it back one sample per clock. The checks compare all outputs at every falling edge. Inputs that reach outputs combinationally change only just after a rising edge, so each sample sees settled values from the matching edge.

// File: rtl/sst_pkg.sv
// Shared types for the synchronous serial transmitter.
// Assumes nothing beyond a two-bit state encoding.
package sst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    localparam int OSR_LONG_SHIFT  = 4;   // 16 cycles per divider step
    localparam int OSR_SHORT_SHIFT = 3;   // 8 cycles per divider step
endpackage

// File: rtl/sst_baud.sv
// Bit timer. While a character runs, it counts input cycles within the
// current bit. It flags the last cycle of the bit (tick) and whether
// the count is in the second half of the bit. The period is
// max(div,1) scaled by 16 or 8, so it is always even and at least 8.
// Assumes div and over8 stay stable during a character.
module sst_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             over8,
    input  logic [DIV_W-1:0] baud_div,
    output logic             tick,
    output logic             second_half
);
    import sst_pkg::*;

    localparam int CNT_W = DIV_W + OSR_LONG_SHIFT;

    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt_q;

    // Work out the bit period from the divider and the oversampling mode.
    always_comb begin
        div_eff     = (baud_div == '0) ? DIV_W'(1) : baud_div;
        period      = over8 ? (CNT_W'(div_eff) << OSR_SHORT_SHIFT)
                            : (CNT_W'(div_eff) << OSR_LONG_SHIFT);
        half        = period >> 1;
        tick        = run && (cnt_q == period - CNT_W'(1));
        second_half = (cnt_q >= half);
    end

    // Cycle counter within the bit. It restarts at each bit boundary and when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sst_frame.sv
// Character sequencer. It holds one waiting word, moves it into the
// shifter, and steps through start, data and stop bits on each bit
// tick. It drives the data line and the completion flag.
// Assumes word9 is stable during a character. With word9=0 the top
// bit of a word is loaded but never sent.
module sst_frame #(
    parameter int DATA_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                word9,
    input  logic                wr_valid,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                tick,
    output logic                wr_ready,
    output logic                hold_full,
    output sst_pkg::tx_state_e  st,
    output logic                last_bit,
    output logic                tx_data,
    output logic                tc
);
    import sst_pkg::*;

    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic              accept;
    logic              load;

    // Handshake, load condition and data line level.
    always_comb begin
        wr_ready = en && !hold_full;
        accept   = wr_valid && wr_ready;
        load     = hold_full && en && ((st == ST_IDLE) || ((st == ST_STOP) && tick));
        last_idx = word9 ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
        last_bit = (st == ST_DATA) && (idx_q == last_idx);
        unique case (st)
            ST_START: tx_data = 1'b0;
            ST_DATA:  tx_data = sh_q[0];
            default:  tx_data = 1'b1;
        endcase
    end

    // Bit sequencer and shifter, least significant bit first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            st    <= ST_START;
            sh_q  <= hold_q;
            idx_q <= '0;
        end else if (tick) begin
            unique case (st)
                ST_START: st <= ST_DATA;
                ST_DATA: begin
                    sh_q <= sh_q >> 1;
                    if (last_bit) st <= ST_STOP;
                    else          idx_q <= idx_q + IDX_W'(1);
                end
                ST_STOP:  st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // One-word holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (accept) begin
            hold_q    <= wr_data;
            hold_full <= 1'b1;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    // Completion flag. A new word clears it, and the end of a stop bit with nothing waiting sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= 1'b1;
        end else if (accept) begin
            tc <= 1'b0;
        end else if ((st == ST_STOP) && tick && !hold_full) begin
            tc <= 1'b1;
        end
    end
endmodule

// File: rtl/sst_clkgen.sv
// Serial clock shaper. Outside data bits the clock sits at the idle
// polarity. Inside a data bit it is active for one half of the bit,
// chosen by the phase setting. The final bit is left unclocked when
// last-bit clocking is off.
// Assumes second_half comes from the bit timer of the same bit.
module sst_clkgen (
    input  logic cpol,
    input  logic cpha,
    input  logic last_clk,
    input  logic data_phase,
    input  logic last_bit,
    input  logic second_half,
    output logic tx_clk
);
    logic active;

    // Select the active half of the bit and apply the polarity.
    always_comb begin
        active = data_phase && (!last_bit || last_clk) && (cpha ? !second_half : second_half);
        tx_clk = cpol ^ active;
    end
endmodule

// File: rtl/sync_serial_tx.sv
// Synchronous serial transmitter, master only. It sends framed
// characters with a clock that runs only during data bits.
// Assumes the configuration inputs stay stable while a character is in flight.
module sync_serial_tx #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_global,
    input  logic             en_tx,
    input  logic             dma_en,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             last_clk,
    input  logic             word9,
    input  logic             over8,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             wr_valid,
    input  logic [8:0]       wr_data,
    output logic             wr_ready,
    output logic             dma_req,
    output logic             tx_data,
    output logic             tx_clk,
    output logic             txe,
    output logic             tc
);
    import sst_pkg::*;

    logic      en;
    logic      tick;
    logic      second_half;
    logic      hold_full;
    logic      last_bit;
    tx_state_e st;

    // Combined enable, empty flag and DMA request.
    always_comb begin
        en      = en_global && en_tx;
        txe     = !hold_full;
        dma_req = dma_en && en && !hold_full;
    end

    sst_baud #(.DIV_W(DIV_W)) u_baud (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (st != ST_IDLE),
        .over8       (over8),
        .baud_div    (baud_div),
        .tick        (tick),
        .second_half (second_half)
    );

    sst_frame #(.DATA_W(9)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .word9     (word9),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .tick      (tick),
        .wr_ready  (wr_ready),
        .hold_full (hold_full),
        .st        (st),
        .last_bit  (last_bit),
        .tx_data   (tx_data),
        .tc        (tc)
    );

    sst_clkgen u_clkgen (
        .cpol        (cpol),
        .cpha        (cpha),
        .last_clk    (last_clk),
        .data_phase  (st == ST_DATA),
        .last_bit    (last_bit),
        .second_half (second_half),
        .tx_clk      (tx_clk)
    );
endmodule

// File: rtl/sst_checker.sv
// Property checker for sync_serial_tx, attached with bind below.
// Assumes it sees the top module's ports and internal sequencer signals.
module sst_checker (
    input logic               clk,
    input logic               rst_n,
    input logic               en_global,
    input logic               en_tx,
    input logic               dma_en,
    input logic               cpol,
    input logic               last_clk,
    input logic               wr_valid,
    input logic               wr_ready,
    input logic               txe,
    input logic               tc,
    input logic               dma_req,
    input logic               tx_clk,
    input sst_pkg::tx_state_e st,
    input logic               tick,
    input logic               last_bit
);
    import sst_pkg::*;

    // R4: no clock activity outside data bits
    p_clk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_DATA) |-> (tx_clk == cpol));

    // R6: final bit unclocked when last-bit clocking is off
    p_last_bit_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !last_clk) |-> (tx_clk == cpol));

    // R3: a bit period is never a single cycle
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R7: no writes taken while disabled
    p_no_write_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_global && en_tx) |-> !wr_ready);

    // R8: a waiting word leaves the holding register on the next edge when idle
    p_load_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!txe && (st == ST_IDLE) && en_global && en_tx) |=> (txe && (st == ST_START)));

    // R10: an accepted word clears the completion flag and fills the holding register
    p_accept_clears_tc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!tc && !txe));

    // R11: a DMA request only when the holding register is empty and DMA is on
    p_dma_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (txe && dma_en));
endmodule

bind sync_serial_tx sst_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_global (en_global),
    .en_tx     (en_tx),
    .dma_en    (dma_en),
    .cpol      (cpol),
    .last_clk  (last_clk),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .txe       (txe),
    .tc        (tc),
    .dma_req   (dma_req),
    .tx_clk    (tx_clk),
    .st        (st),
    .tick      (tick),
    .last_bit  (last_bit)
);

// File: tb/sync_serial_tx_bench.sv
module sync_serial_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_global = 1'b1, en_tx = 1'b1, dma_en = 1'b0;
    logic             cpol = 1'b0, cpha = 1'b0, last_clk = 1'b1;
    logic             word9 = 1'b0, over8 = 1'b0;
    logic [DIV_W-1:0] baud_div = DIV_W'(1);
    logic             wr_valid = 1'b0;
    logic [8:0]       wr_data = '0;
    logic             wr_ready, dma_req, tx_data, tx_clk, txe, tc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_serial_tx #(.DIV_W(DIV_W)) u_sync_serial_tx (
        .clk(clk), .rst_n(rst_n), .en_global(en_global), .en_tx(en_tx),
        .dma_en(dma_en), .cpol(cpol), .cpha(cpha), .last_clk(last_clk),
        .word9(word9), .over8(over8), .baud_div(baud_div),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .dma_req(dma_req), .tx_data(tx_data), .tx_clk(tx_clk),
        .txe(txe), .tc(tc)
    );

    // Reference model: the waiting word, the queued per-cycle waveform {data, clock active}, and the flags.
    logic [1:0] wave_q[$];
    logic [1:0] cur = 2'b10;
    bit         pend_full = 0;
    logic [8:0] pend_word = '0;
    bit         in_frame = 0;
    bit         tc_m = 1;

    task automatic chk(input string req, input string nm, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
        end
    endtask

    // Build a whole character from the requirements: R1 framing, R2 length, R3 period, R5 halves, R6 last bit.
    task automatic build_frame(input logic [8:0] w);
        int nb = word9 ? 9 : 8;
        int d  = (baud_div == 0) ? 1 : int'(baud_div);
        int p  = d * (over8 ? 8 : 16);
        for (int b = 0; b < nb + 2; b++) begin
            for (int c = 0; c < p; c++) begin
                logic dv;
                logic act;
                dv  = (b == 0) ? 1'b0 : (b == nb + 1) ? 1'b1 : w[b-1];
                act = (b >= 1) && (b <= nb) && ((b != nb) || last_clk)
                      && (cpha ? (c < p/2) : (c >= p/2));
                wave_q.push_back({dv, act});
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            wave_q.delete();
            cur = 2'b10; pend_full = 0; in_frame = 0; tc_m = 1;
        end else begin
            bit en_now;
            bit ready_old;
            en_now    = en_global && en_tx;
            ready_old = en_now && !pend_full;
            if (wave_q.size() == 0 && pend_full && en_now) begin
                build_frame(pend_word);
                pend_full = 0;
            end
            if (wave_q.size() > 0) begin
                cur = wave_q.pop_front();
                in_frame = 1;
            end else begin
                cur = 2'b10;
                if (in_frame) begin
                    in_frame = 0;
                    if (!pend_full) tc_m = 1;
                end
            end
            if (wr_valid && ready_old) begin
                pend_word = wr_data;
                pend_full = 1;
                tc_m = 0;
            end
        end
    end

    // Compare every output at every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit en_now;
            en_now = en_global && en_tx;
            chk("R1", "tx_data", tx_data, cur[1]);
            chk("R5", "tx_clk", tx_clk, cpol ^ cur[0]);
            chk("R9", "txe", txe, !pend_full);
            chk("R10", "tc", tc, tc_m);
            chk("R7", "wr_ready", wr_ready, en_now && !pend_full);
            chk("R11", "dma_req", dma_req, dma_en && en_now && !pend_full);
        end
    end

    task automatic send(input logic [8:0] w);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!(tc && txe)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input logic pol, input logic pha, input logic lc,
                           input logic w9, input logic o8, input int dv);
        @(posedge clk); #1;
        cpol = pol; cpha = pha; last_clk = lc; word9 = w9; over8 = o8;
        baud_div = DIV_W'(dv);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12: reset state
        @(negedge clk);
        chk("R12", "tx_data", tx_data, 1);
        chk("R12", "tx_clk", tx_clk, 0);
        chk("R12", "txe", txe, 1);
        chk("R12", "tc", tc, 1);

        // R1 R5: mode 0, one byte, then two back to back (R8: no idle bit in between)
        send(9'h0A5);
        wait_done();
        send(9'h03C); send(9'h0C3);
        wait_done();
        // R4 R5: the other three clock modes, back to back
        set_cfg(0, 1, 1, 0, 0, 1); send(9'h081); send(9'h07E); wait_done();
        set_cfg(1, 0, 1, 0, 0, 1); send(9'h055); send(9'h0AA); wait_done();
        set_cfg(1, 1, 1, 0, 0, 1); send(9'h0F0); wait_done();
        // R6: final data bit left unclocked
        set_cfg(0, 0, 0, 0, 0, 1); send(9'h0FF); send(9'h001); wait_done();
        set_cfg(1, 1, 0, 0, 0, 1); send(9'h080); wait_done();
        // R2: nine data bits, and bit 8 ignored in 8-bit mode
        set_cfg(0, 0, 1, 1, 0, 1); send(9'h1A5); send(9'h0FF); wait_done();
        set_cfg(0, 0, 1, 0, 0, 1); send(9'h100); wait_done();
        // R3: divider 0 acts as 1, a larger divider, and 8x oversampling
        set_cfg(0, 0, 1, 0, 0, 0); send(9'h0B4); wait_done();
        set_cfg(0, 1, 1, 0, 0, 3); send(9'h05A); wait_done();
        set_cfg(1, 0, 1, 1, 1, 2); send(9'h133); send(9'h0CC); wait_done();
        set_cfg(0, 0, 0, 0, 1, 1); send(9'h069); wait_done();
        // R11: DMA requests follow the empty flag
        @(posedge clk); #1 dma_en = 1'b1;
        send(9'h011); send(9'h022); wait_done();
        @(posedge clk); #1 dma_en = 1'b0;
        // R7: writes ignored while the transmitter is disabled
        @(posedge clk); #1 en_tx = 1'b0;
        @(negedge clk); wr_valid = 1'b1; wr_data = 9'h0EE;
        repeat (20) @(negedge clk);
        wr_valid = 1'b0;
        @(posedge clk); #1 en_tx = 1'b1;
        repeat (5) @(negedge clk);
        // R7: a running character finishes after the global enable drops, and the waiting word stays
        send(9'h0D2); send(9'h02D);
        repeat (30) @(posedge clk);
        #1 en_global = 1'b0;
        repeat (400) @(posedge clk);
        #1 en_global = 1'b1;
        wait_done();
        // R10: tc must stay set while idle
        repeat (10) @(negedge clk);
        chk("R10", "tc idle", tc, 1);
        finish_run();
    end
endmodule